// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of sixteen transmit descriptors kept in a byte-wide descriptor memory and sends every packet that is ready to a byte-stream consumer. A one-cycle `demand` pulse starts a walk at the block's saved ring index. For each entry it reads the flag byte. When that byte marks a complete packet owned by the controller, the block reads the stored length and negates it to get the byte count. It then streams that many bytes from the entry's buffer slot, writes the flag byte back so the host owns the entry again, and pulses `txDone`. The host-side status logic uses that pulse to raise its transmit interrupt.

A walk visits fifteen entries at most. It stops at the entry just before the one it started from. The saved index moves forward by one for each packet sent, and it does not follow the scan position. While `stopReq` is high, demands are refused. The memory port is a simple synchronous one: read data returns on the cycle after the request.

Top module: `txring_walker`

## Requirements
- R1: After reset, `txValid`, `memEn` and `txDone` are low and the saved ring index is 0.
- R2: A `demand` pulse seen while idle with `stopReq` low starts a walk at the saved index s. The walk visits s, s+1, … modulo 16 and ends without visiting entry (s-1) mod 16.
- R3: Descriptor i sits at `DESC_BASE + 8*i`. Its flag byte is at offset 2. It is sent only when the flag byte equals exactly 8'h83 (owner bit 7, start bit 1, end bit 0). Any other value is skipped with no write and no output.
- R4: The 16-bit length sits at offsets 4 (low byte) and 5 (high byte) and holds the negated byte count. The count is its two's complement modulo 65536, so a value of 0 sends no bytes.
- R5: Buffer slot i starts at `BUF_BASE + 1544*i`. Its bytes leave in ascending address order, and `txLast` is high only with the final byte.
- R6: A byte transfers when `txValid` and `txReady` are both high. While stalled, `txData` and `txLast` hold steady.
- R7: After the last byte, or straight away for a zero count, the block writes 8'h03 to the flag byte, with owner bit 7 and error bit 6 cleared. In that same cycle it pulses `txDone` high for exactly one cycle.
- R8: The saved index advances by one modulo 16 for each packet sent, whatever entry that packet came from.
- R9: A count above 1544 is clamped to 1544 bytes, and the flag byte is written back as 8'h43 (error bit 6 set).
- R10: With `stopReq` high a demand starts nothing and no memory access follows. A demand that arrives during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| demand | input | 1 | Start-walk pulse |
| stopReq | input | 1 | Blocks new walks while high |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Memory write when high, read when low |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read request |
| txValid | output | 1 | Output byte valid |
| txData | output | 8 | Output byte |
| txLast | output | 1 | Marks the final byte of a packet |
| txReady | input | 1 | Consumer accepts the byte |
| txDone | output | 1 | One-cycle pulse per packet handed back |

## Verification
The assertions take for granted that read data arrives exactly one cycle after a read request, and that no other agent changes a descriptor or buffer while a walk is in progress. The bench memory answers every read on the next clock, and the bench changes descriptors only between walks, once the outputs have been idle for a settling window. `txReady` follows three patterns: always high, alternating, and pseudo-random. `demand` is a single-cycle pulse, including one sent deliberately in the middle of a walk.

// File: rtl/txwalk_pkg.sv
package txwalk_pkg;
  localparam logic [7:0] FLAG_OWN = 8'h80;
  localparam logic [7:0] FLAG_ERR = 8'h40;
  localparam logic [7:0] FLAG_SOP = 8'h02;
  localparam logic [7:0] FLAG_EOP = 8'h01;
  localparam logic [7:0] FLAG_READY = FLAG_OWN | FLAG_SOP | FLAG_EOP;
  localparam logic [7:0] FLAG_HANDBACK = FLAG_READY & ~(FLAG_OWN | FLAG_ERR);

  localparam int DESC_STRIDE = 8;
  localparam int FLAG_OFS = 2;
  localparam int LEN_LO_OFS = 4;
  localparam int LEN_HI_OFS = 5;

  typedef enum logic [2:0] {
    MEM_NONE, MEM_RD_FLAG, MEM_RD_LEN_LO, MEM_RD_LEN_HI, MEM_RD_BUF, MEM_WR_FLAG
  } memOpT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_FLAGS, ST_READ_LEN, ST_STREAM, ST_WRITEBACK, ST_NEXT
  } walkStateT;

  typedef struct packed {
    logic  startScan;
    logic  advScan;
    logic  capLenLo;
    logic  capLenHi;
    logic  capByte;
    logic  advByte;
    logic  bumpSaved;
    memOpT memOp;
  } ctlStrobeT;

  typedef struct packed {
    logic flagReady;
    logic cntZero;
    logic lastByte;
    logic lapEnd;
  } dpStatusT;
endpackage

// File: rtl/txwalk_ctrl.sv
module txwalk_ctrl
  import txwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       demand,
  input  logic       stopReq,
  input  logic       txReady,
  input  dpStatusT   status,
  output ctlStrobeT  stb,
  output logic       txValid,
  output logic       txDone
);
  walkStateT state, nState;
  logic [1:0] sub, nSub;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      sub   <= 2'd0;
    end else begin
      state <= nState;
      sub   <= nSub;
    end
  end

  always_comb begin
    stb     = '0;
    nState  = state;
    nSub    = sub;
    txValid = 1'b0;
    txDone  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (demand && !stopReq) begin
          stb.startScan = 1'b1;
          nState = ST_READ_FLAGS;
          nSub   = 2'd0;
        end
      end
      ST_READ_FLAGS: begin
        if (sub == 2'd0) begin
          stb.memOp = MEM_RD_FLAG;
          nSub = 2'd1;
        end else begin
          nSub   = 2'd0;
          nState = status.flagReady ? ST_READ_LEN : ST_NEXT;
        end
      end
      ST_READ_LEN: begin
        case (sub)
          2'd0: begin
            stb.memOp = MEM_RD_LEN_LO;
            nSub = 2'd1;
          end
          2'd1: begin
            stb.capLenLo = 1'b1;
            stb.memOp = MEM_RD_LEN_HI;
            nSub = 2'd2;
          end
          default: begin
            stb.capLenHi = 1'b1;
            nSub   = 2'd0;
            nState = ST_STREAM;
          end
        endcase
      end
      ST_STREAM: begin
        case (sub)
          2'd0: begin
            if (status.cntZero) begin
              nState = ST_WRITEBACK;
            end else begin
              stb.memOp = MEM_RD_BUF;
              nSub = 2'd1;
            end
          end
          2'd1: begin
            stb.capByte = 1'b1;
            nSub = 2'd2;
          end
          default: begin
            txValid = 1'b1;
            if (txReady) begin
              nSub = 2'd0;
              if (status.lastByte) nState = ST_WRITEBACK;
              else stb.advByte = 1'b1;
            end
          end
        endcase
      end
      ST_WRITEBACK: begin
        stb.memOp     = MEM_WR_FLAG;
        stb.bumpSaved = 1'b1;
        txDone        = 1'b1;
        nState        = ST_NEXT;
      end
      ST_NEXT: begin
        nSub = 2'd0;
        if (status.lapEnd) begin
          nState = ST_IDLE;
        end else begin
          stb.advScan = 1'b1;
          nState = ST_READ_FLAGS;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!txValid && stb.memOp == MEM_NONE));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stopReq) |=> (state == ST_IDLE));
endmodule

// File: rtl/txwalk_dp.sv
module txwalk_dp
  import txwalk_pkg::*;
#(
  parameter int RING_LOG   = 4,
  parameter int ADDR_W     = 16,
  parameter int SLOT_BYTES = 1544,
  parameter int DESC_BASE  = 0,
  parameter int BUF_BASE   = 256
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         stb,
  input  logic [7:0]        memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        txData,
  output logic              txLast,
  output dpStatusT          status
);
  localparam int CNT_W = $clog2(SLOT_BYTES + 1);
  localparam logic [15:0] SLOT_LIMIT = 16'(SLOT_BYTES);

  logic [RING_LOG-1:0] savedIdx, scanIdx, endIdx, nextScan;
  logic [7:0]          lenLo, holdByte;
  logic [CNT_W-1:0]    cnt, byteIdx;
  logic                errFlag;
  logic [15:0]         rawLen, negLen;
  logic [ADDR_W-1:0]   descAddr, bufAddr;

  assign nextScan = scanIdx + 1'b1;
  assign rawLen   = {memRdata, lenLo};
  assign negLen   = ~rawLen + 16'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedIdx <= '0;
      scanIdx  <= '0;
      endIdx   <= '0;
      lenLo    <= '0;
      holdByte <= '0;
      cnt      <= '0;
      byteIdx  <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (stb.startScan) begin
        scanIdx <= savedIdx;
        endIdx  <= savedIdx - 1'b1;
      end
      if (stb.advScan) scanIdx <= nextScan;
      if (stb.capLenLo) lenLo <= memRdata;
      if (stb.capLenHi) begin
        byteIdx <= '0;
        if (negLen > SLOT_LIMIT) begin
          cnt     <= CNT_W'(SLOT_BYTES);
          errFlag <= 1'b1;
        end else begin
          cnt     <= CNT_W'(negLen);
          errFlag <= 1'b0;
        end
      end
      if (stb.capByte) holdByte <= memRdata;
      if (stb.advByte) byteIdx <= byteIdx + 1'b1;
      if (stb.bumpSaved) savedIdx <= savedIdx + 1'b1;
    end
  end

  assign descAddr = ADDR_W'(DESC_BASE) + ADDR_W'(scanIdx) * ADDR_W'(DESC_STRIDE);
  assign bufAddr  = ADDR_W'(BUF_BASE) + ADDR_W'(scanIdx) * ADDR_W'(SLOT_BYTES)
                  + ADDR_W'(byteIdx);

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    case (stb.memOp)
      MEM_RD_FLAG:   memAddr = descAddr + ADDR_W'(FLAG_OFS);
      MEM_RD_LEN_LO: memAddr = descAddr + ADDR_W'(LEN_LO_OFS);
      MEM_RD_LEN_HI: memAddr = descAddr + ADDR_W'(LEN_HI_OFS);
      MEM_RD_BUF:    memAddr = bufAddr;
      MEM_WR_FLAG: begin
        memAddr  = descAddr + ADDR_W'(FLAG_OFS);
        memWdata = FLAG_HANDBACK | (errFlag ? FLAG_ERR : 8'h00);
      end
      default: memAddr = '0;
    endcase
  end

  assign memEn = (stb.memOp != MEM_NONE);
  assign memWe = (stb.memOp == MEM_WR_FLAG);

  assign txData = holdByte;
  assign txLast = ({1'b0, byteIdx} + 1'b1) == {1'b0, cnt};

  assign status.flagReady = (memRdata == FLAG_READY);
  assign status.cntZero   = (cnt == '0);
  assign status.lastByte  = txLast;
  assign status.lapEnd    = (nextScan == endIdx);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(SLOT_BYTES));

  assert_buf_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memOp == MEM_RD_BUF) |-> (byteIdx < cnt));

  assert_saved_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.bumpSaved |=> (savedIdx == $past(savedIdx) + 1'b1));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txwalk_pkg::*;
#(
  parameter int RING_LOG   = 4,
  parameter int ADDR_W     = 16,
  parameter int SLOT_BYTES = 1544,
  parameter int DESC_BASE  = 0,
  parameter int BUF_BASE   = 256
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              demand,
  input  logic              stopReq,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady,
  output logic              txDone
);
  ctlStrobeT stb;
  dpStatusT  status;

  txwalk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .demand(demand), .stopReq(stopReq),
    .txReady(txReady), .status(status), .stb(stb),
    .txValid(txValid), .txDone(txDone)
  );

  txwalk_dp #(
    .RING_LOG(RING_LOG), .ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES),
    .DESC_BASE(DESC_BASE), .BUF_BASE(BUF_BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .txData(txData), .txLast(txLast), .status(status)
  );

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  assert_done_writes_R7: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (memEn && memWe));
endmodule

// File: tb/sim_txring_walker.sv
module sim_txring_walker;
  localparam int SLOT = 1544;
  localparam int DBASE = 0;
  localparam int BBASE = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic demand = 1'b0;
  logic stopReq = 1'b0;
  logic memEn, memWe;
  logic [15:0] memAddr;
  logic [7:0] memWdata;
  logic [7:0] memRdata = 8'h00;
  logic txValid, txLast, txDone;
  logic [7:0] txData;
  logic txReady = 1'b0;

  always #5 clk = ~clk;

  txring_walker u0 (
    .clk(clk), .rstN(rstN), .demand(demand), .stopReq(stopReq),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .txDone(txDone)
  );

  logic [7:0] mem [0:65535];
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else memRdata <= mem[memAddr];
    end
  end

  int checks = 0;
  int failures = 0;
  int readyMode = 0;
  int doneSeen = 0;
  int expDone = 0;
  int memActive = 0;
  int benchSaved = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  int expBytes[$];
  int expWrA[$];
  int expWrD[$];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flagAddr(input int i);
    return DBASE + 8 * i + 2;
  endfunction

  task automatic setDesc(input int i, input int flag, input int count);
    int raw;
    raw = (65536 - count) % 65536;
    mem[flagAddr(i)] = 8'(flag);
    mem[DBASE + 8 * i + 4] = 8'(raw);
    mem[DBASE + 8 * i + 5] = 8'(raw >> 8);
    for (int k = 0; k < SLOT; k++) mem[BBASE + SLOT * i + k] = 8'(i * 37 + k * 5 + 1);
  endtask

  function automatic void planScan();
    int s;
    int stopAt;
    s = benchSaved;
    stopAt = (s + 15) % 16;
    for (int i = s; i != stopAt; i = (i + 1) % 16) begin
      if (mem[flagAddr(i)] == 8'h83) begin
        int raw;
        int cnt;
        bit err;
        raw = {mem[DBASE + 8 * i + 5], mem[DBASE + 8 * i + 4]};
        cnt = (65536 - raw) % 65536;
        err = cnt > SLOT;
        if (err) cnt = SLOT;
        for (int k = 0; k < cnt; k++)
          expBytes.push_back({(k == cnt - 1) ? 1 : 0, mem[BBASE + SLOT * i + k]});
        expWrA.push_back(flagAddr(i));
        expWrD.push_back(err ? 8'h43 : 8'h03);
        expDone++;
        benchSaved = (benchSaved + 1) % 16;
      end
    end
  endfunction

  task automatic pulseDemand(input bit plan);
    @(negedge clk);
    if (plan) planScan();
    demand = 1'b1;
    @(negedge clk);
    demand = 1'b0;
  endtask

  task automatic drain(input string req);
    while (expBytes.size() != 0 || expWrA.size() != 0) @(negedge clk);
    repeat (100) @(negedge clk);
    check(doneSeen == expDone, req, doneSeen, expDone);
  endtask

  // monitor compared on every clock, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (readyMode)
        0: txReady = 1'b1;
        1: txReady = cyc[0];
        default: txReady = lfsr[0];
      endcase
      if (rstN) begin
        if (memEn) memActive++;
        if (txValid && txReady) begin
          if (expBytes.size() == 0) check(1'b0, "R5 unexpected byte", txData, 0);
          else begin
            int e;
            e = expBytes.pop_front();
            check({txLast, txData} == 9'(e), "R5 byte/last", {txLast, txData}, e);
          end
        end
        if (memEn && memWe) begin
          if (expWrA.size() == 0) check(1'b0, "R3 unexpected write", memAddr, 0);
          else begin
            int a;
            int d;
            a = expWrA.pop_front();
            d = expWrD.pop_front();
            check(memAddr == 16'(a), "R7 writeback addr", memAddr, a);
            check(memWdata == 8'(d), "R7 writeback data (R9 error bit)", memWdata, d);
          end
        end
        if (txDone) begin
          doneSeen++;
          check(memEn && memWe, "R7 done with write", {memEn, memWe}, 3);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!txValid && !memEn && !txDone, "R1 reset outputs", {txValid, memEn, txDone}, 0);

    // S1: saved 0, entries 0,1 and 15 ready; 15 is the excluded entry; busy demand ignored
    setDesc(0, 8'h83, 3);
    setDesc(1, 8'h83, 5);
    setDesc(15, 8'h83, 2);
    readyMode = 0;
    pulseDemand(1'b1);
    repeat (8) @(negedge clk);
    pulseDemand(1'b0);
    drain("R2 R10 walk from 0");
    check(mem[flagAddr(15)] == 8'h83, "R2 entry before start untouched", mem[flagAddr(15)], 8'h83);

    // S2: saved 2, non-exact flags skipped, length 0xFFFF gives one byte; entry 15 now sent
    setDesc(2, 8'h80, 4);
    setDesc(3, 8'hC3, 4);
    setDesc(4, 8'h83, 1);
    readyMode = 1;
    pulseDemand(1'b1);
    drain("R3 R4 exact match");
    check(mem[flagAddr(2)] == 8'h80 && mem[flagAddr(3)] == 8'hC3, "R3 skipped flags kept",
          {mem[flagAddr(2)], mem[flagAddr(3)]}, 16'h80C3);

    // S3: saved 4 (R8: two sends moved it from 2 to 4); entry 3 excluded; entry 5 zero length
    setDesc(3, 8'h83, 6);
    setDesc(5, 8'h83, 0);
    pulseDemand(1'b1);
    drain("R4 R8 zero length and saved index");
    check(mem[flagAddr(3)] == 8'h83, "R2 R8 excluded entry 3 kept", mem[flagAddr(3)], 8'h83);

    // S4: stop blocks, then release
    stopReq = 1'b1;
    memActive = 0;
    pulseDemand(1'b0);
    repeat (60) @(negedge clk);
    check(memActive == 0, "R10 stop blocks walk", memActive, 0);
    check(mem[flagAddr(3)] == 8'h83, "R10 flag intact under stop", mem[flagAddr(3)], 8'h83);
    stopReq = 1'b0;
    @(negedge clk);
    pulseDemand(1'b1);
    drain("R10 walk after stop release");

    // S5: clamp above slot size and exact slot size, random backpressure
    setDesc(6, 8'h83, 2000);
    setDesc(7, 8'h83, SLOT);
    readyMode = 2;
    pulseDemand(1'b1);
    drain("R9 clamp");
    check(mem[flagAddr(6)] == 8'h43, "R9 error flag", mem[flagAddr(6)], 8'h43);
    check(mem[flagAddr(7)] == 8'h03, "R7 handback flag", mem[flagAddr(7)], 8'h03);
    check(expBytes.size() == 0 && expWrA.size() == 0, "R6 all transfers seen",
          expBytes.size(), 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule